// File: doc/BRIEF.md
# SPI Interrupt Status and Clear Unit

This block gathers the four event strobes of an SPI engine into a set of sticky
flags and drives one interrupt request. Each flag sets on its strobe and holds
until software clears it. Software clears a flag by writing a one to its bit in
a dedicated clear register. Four enable bits in the control word gate the flags
into a masked view. The interrupt output is the OR of the masked view, delayed
by one register stage.

Software reaches the unit through a simple synchronous register port. A write
takes effect at the clock edge where it is sampled. Read data is returned one
cycle after the read strobe, with a valid flag. Software can read the raw flags
and the masked flags separately. A masked value of zero means this unit is not
requesting service, so the request line can be shared with other units.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset, all flags, all enables, `irq_o` and `rd_valid_o` are zero, and every register reads as zero.
- R2: Source bits follow a fixed order: bit 0 is transmit done, bit 1 is receive data ready, bit 2 is receive overflow and bit 3 is transmit underrun. A one on `evt_i[i]` in a cycle sets raw flag i at that edge. The flag stays set until it is cleared.
- R3: A write to offset 0x0C clears each raw flag whose bit in `wdata_i[3:0]` is one. It leaves every other flag unchanged. The clear register reads as zero.
- R4: When a flag's event strobe and its clear arrive in the same cycle, the flag ends up set.
- R5: The control word at offset 0x00 holds the enables in bits 4..7. Bit 4 enables receive data ready (source 1). Bit 5 enables transmit done (source 0). Bit 6 enables receive overflow (source 2). Bit 7 enables transmit underrun (source 3). The other control bits are not stored and read as zero.
- R6: Offset 0x20 reads the masked flags, which are the raw flags ANDed with their enables, in bits 3:0. Offset 0x24 reads the raw flags in bits 3:0, whatever the enables are.
- R7: `irq_o` is high in the cycle after the masked flags are non-zero.
- R8: `irq_o` is low in the cycle after the masked flags are all zero, so the line may be shared.
- R9: `rd_valid_o` and `rdata_o` are updated one cycle after `rd_en_i`. Unmapped offsets read as zero.
- R10: Writes to the read-only offsets 0x20 and 0x24 do not change any flag or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| rd_valid_o | output | 1 | Read data valid |
| evt_i | input | 4 | Event strobes, in source bit order |
| irq_o | output | 1 | Interrupt request |

## Verification
Each event is first raised on its own while all enables are off. This separates the raw view from the masked view, and it shows that the request line stays quiet. Each enable bit is then set on its own. This checks the swapped pairing of control bits 4 and 5 with sources 1 and 0, which a straight mapping would get wrong. Clear masks with mixed ones and zeros show that only the selected flags drop. An event arriving in the same cycle as its clear shows the set-over-clear priority. Writes to the read-only offsets and to unmapped offsets show they have no effect. A behavioural model is compared with the outputs on every cycle, and this exposes any error of one cycle in the request or the read path.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NSRC   = 4;
  localparam int unsigned EN_LSB = 4;
  localparam int unsigned USED_W = EN_LSB + NSRC;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_MIS  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_RIS  = 8'h24;

  typedef enum logic [1:0] {
    SRC_TX_DONE  = 2'd0,
    SRC_RX_READY = 2'd1,
    SRC_RX_OVF   = 2'd2,
    SRC_TX_UNDER = 2'd3
  } src_e;

  // Position inside the enable field that gates a given source.
  function automatic int unsigned en_pos(input int unsigned src);
    case (src)
      0:       en_pos = 1;
      1:       en_pos = 0;
      default: en_pos = src;
    endcase
  endfunction

  // Reorder the enable field into source order.
  function automatic logic [NSRC-1:0] enables_to_mask(input logic [NSRC-1:0] fld);
    logic [NSRC-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NSRC; i++) begin
      m[i] = fld[en_pos(i)];
    end
    return m;
  endfunction

  // Place the enable field at its bit position in the control word.
  function automatic logic [DATA_W-1:0] ctrl_view(input logic [NSRC-1:0] fld);
    logic [DATA_W-1:0] v;
    v = '0;
    v[EN_LSB +: NSRC] = fld;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] flags_view(input logic [NSRC-1:0] f);
    logic [DATA_W-1:0] v;
    v = '0;
    v[NSRC-1:0] = f;
    return v;
  endfunction
endpackage

// File: rtl/spi_irq_ctrl_reg.sv
module spi_irq_ctrl_reg
  import spi_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [NSRC-1:0] fld_i,
  output logic [NSRC-1:0] fld_o,
  output logic [NSRC-1:0] src_en_o
);
  logic [NSRC-1:0] fld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fld_q <= '0;
    else if (wr_i) fld_q <= fld_i;
  end

  assign fld_o    = fld_q;
  assign src_en_o = enables_to_mask(fld_q);
endmodule

// File: rtl/spi_irq_raw_bank.sv
module spi_irq_raw_bank
  import spi_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] raw_o
);
  logic [NSRC-1:0] raw_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        raw_q[i] <= 1'b0;
      else if (evt_i[i]) raw_q[i] <= 1'b1;
      else if (clr_i[i]) raw_q[i] <= 1'b0;
    end
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/spi_irq_rd_port.sv
module spi_irq_rd_port
  import spi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   en_fld_i,
  input  logic [NSRC-1:0]   raw_i,
  input  logic [NSRC-1:0]   masked_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_comb begin
    case (addr_i)
      OFF_CTRL: sel = ctrl_view(en_fld_i);
      OFF_MIS:  sel = flags_view(masked_i);
      OFF_RIS:  sel = flags_view(raw_i);
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= sel;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_valid_o,
  input  logic [NSRC-1:0]   evt_i,
  output logic              irq_o
);
  logic            wr_ctrl;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] en_fld;
  logic [NSRC-1:0] src_en;
  logic [NSRC-1:0] raw_q;
  logic [NSRC-1:0] masked_vec;
  logic            irq_q;
  logic            unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DATA_W-1:USED_W];

  assign wr_ctrl = wr_en_i && (addr_i == OFF_CTRL);
  assign clr_vec = (wr_en_i && (addr_i == OFF_CLR)) ? wdata_i[NSRC-1:0] : '0;

  spi_irq_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_ctrl),
    .fld_i    (wdata_i[EN_LSB +: NSRC]),
    .fld_o    (en_fld),
    .src_en_o (src_en)
  );

  spi_irq_raw_bank u_raw (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (evt_i),
    .clr_i (clr_vec),
    .raw_o (raw_q)
  );

  assign masked_vec = raw_q & src_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |masked_vec;
  end

  assign irq_o = irq_q;

  spi_irq_rd_port u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_i     (rd_en_i),
    .addr_i   (addr_i),
    .en_fld_i (en_fld),
    .raw_i    (raw_q),
    .masked_i (masked_vec),
    .rdata_o  (rdata_o),
    .rvalid_o (rd_valid_o)
  );
endmodule

// File: rtl/spi_irq_unit_chk.sv
module spi_irq_unit_chk
  import spi_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt,
  input logic [NSRC-1:0] clr,
  input logic [NSRC-1:0] raw,
  input logic [NSRC-1:0] masked,
  input logic            irq,
  input logic            rd_en,
  input logic            rd_valid
);
  // R2 / R4: a strobe always leaves its flag set, even when it meets a clear
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((raw & $past(evt)) == $past(evt)));

  // R3: cleared flags without a competing strobe drop
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~evt) != '0) |=> ((raw & $past(clr & ~evt)) == '0));

  // R3: flags that were not cleared never drop
  a_r3_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (raw != '0) |=> ((($past(raw) & ~$past(clr)) & ~raw) == '0));

  // R6: the masked view never shows a flag that is not raised
  a_r6_masked_subset: assert property (@(posedge clk) disable iff (!rst_n)
    ((masked & ~raw) == '0));

  // R7
  a_r7_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (masked != '0) |=> irq);

  // R8
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (masked == '0) |=> !irq);

  // R9
  a_r9_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

bind spi_irq_unit spi_irq_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt      (evt_i),
  .clr      (clr_vec),
  .raw      (raw_q),
  .masked   (masked_vec),
  .irq      (irq_o),
  .rd_en    (rd_en_i),
  .rd_valid (rd_valid_o)
);

// File: tb/spi_irq_unit_bench.sv
`timescale 1ns/1ps
module spi_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic [3:0]  evt = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_irq_unit u_spi_irq_unit (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rd_valid_o(rd_valid),
    .evt_i(evt), .irq_o(irq)
  );

  // Behavioural reference
  int unsigned m_raw, m_en, m_rdata;
  bit m_irq, m_rvalid;

  function automatic int unsigned gate(int unsigned raw, int unsigned en);
    int unsigned m;
    m = 0;
    if (en[1]) m |= 1;   // ctrl bit 5 -> transmit done
    if (en[0]) m |= 2;   // ctrl bit 4 -> receive ready
    if (en[2]) m |= 4;
    if (en[3]) m |= 8;
    return raw & m;
  endfunction

  function automatic int unsigned view(int unsigned a);
    if (a == 'h00) return m_en << 4;
    if (a == 'h20) return gate(m_raw, m_en);
    if (a == 'h24) return m_raw;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_raw = 0; m_en = 0; m_rdata = 0; m_irq = 0; m_rvalid = 0;
    end else begin
      int unsigned clr;
      m_rvalid = rd_en;
      if (rd_en) m_rdata = view(addr);
      m_irq = (gate(m_raw, m_en) != 0);
      clr = (wr_en && addr == 8'h0C) ? wdata[3:0] : 0;
      m_raw = (m_raw & ~clr & 'hF) | evt;
      if (wr_en && addr == 8'h00) m_en = wdata[7:4];
    end
  end

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check("R7/R8 irq vs model", irq, m_irq);
      check("R9 rd_valid vs model", rd_valid, m_rvalid);
      if (m_rvalid) check("R9 rdata vs model", rdata, m_rdata);
    end
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic reg_wr(logic [7:0] a, logic [31:0] d, logic [3:0] e = 0);
    addr = a; wdata = d; wr_en = 1; evt = e;
    @(negedge clk);
    wr_en = 0; evt = 0; wdata = '0;
  endtask

  task automatic reg_rd(logic [7:0] a, logic [31:0] exp, string tag);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    check(tag, rdata, exp);
  endtask

  task automatic pulse(logic [3:0] e);
    evt = e;
    @(negedge clk);
    evt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq at reset", irq, 0);
    check("R1 rd_valid at reset", rd_valid, 0);
    rst_n = 1;
    @(negedge clk);
    reg_rd(8'h00, 0, "R1 ctrl reset");
    reg_rd(8'h24, 0, "R1 raw reset");
    reg_rd(8'h20, 0, "R1 masked reset");

    // each source alone, enables off
    for (int i = 0; i < 4; i++) begin
      pulse(4'(1 << i));
      reg_rd(8'h24, 32'(1 << i), "R2 raw bit per source");
      reg_rd(8'h20, 0, "R6 masked zero with enables off");
      check("R8 irq low with enables off", irq, 0);
      reg_wr(8'h0C, 32'hF);
    end
    pulse(4'b0100);
    repeat (3) @(negedge clk);
    reg_rd(8'h24, 32'h4, "R2 flag sticky");
    reg_wr(8'h0C, 32'hF);

    // enable mapping, one control bit at a time
    pulse(4'hF);
    for (int b = 0; b < 4; b++) begin
      int unsigned exp_src;
      exp_src = (b == 0) ? 2 : (b == 1) ? 1 : (1 << b);
      reg_wr(8'h00, 32'(1 << (4 + b)));
      reg_rd(8'h00, 32'(1 << (4 + b)), "R5 control readback");
      reg_rd(8'h20, exp_src, "R5 enable bit gates its source");
      reg_rd(8'h24, 32'hF, "R6 raw ignores enables");
    end
    reg_wr(8'h00, 32'hFFFF_FF0F);
    reg_rd(8'h00, 0, "R5 other control bits not stored");
    check("R8 irq low after enables cleared", irq, 0);

    // irq latency
    reg_wr(8'h00, 32'h0000_00F0);
    check("R7 irq not yet high", irq, 0);
    @(negedge clk);
    check("R7 irq high one cycle later", irq, 1);

    // partial clear
    reg_wr(8'h0C, 32'h5);
    reg_rd(8'h24, 32'hA, "R3 only selected flags clear");
    reg_rd(8'h0C, 0, "R3 clear register reads zero");

    // set beats clear
    reg_wr(8'h0C, 32'hA, 4'b0010);
    reg_rd(8'h24, 32'h2, "R4 event wins over clear");

    // read-only offsets
    reg_wr(8'h24, 32'hFFFF_FFFF);
    reg_wr(8'h20, 32'hFFFF_FFFF);
    reg_rd(8'h24, 32'h2, "R10 raw unchanged by read-only write");
    reg_rd(8'h00, 32'hF0, "R10 enables unchanged by read-only write");
    reg_rd(8'h10, 0, "R9 unmapped reads zero");

    // drop request
    reg_wr(8'h0C, 32'hF);
    @(negedge clk);
    check("R8 irq low after all cleared", irq, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule